// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Traps

This block decides which pending event a small CPU should service next. It has two kinds of source. User sources each carry a pending flag, an enable bit and a 3-bit priority field. Trap sources sit on fixed levels above every user level and cannot be masked. The block holds the CPU's current 4-bit priority level and a stack of saved levels, so that handlers can nest. When a source wins, the block pushes the old level, raises the current level and pulses a take strobe for one cycle together with a vector index.

Software controls the block through a few strobes:
- Write a source's priority field.
- Clear pending flags.
- Overwrite the current level directly.
- Start a timed mask that holds off user levels 1 to 6 for a counted number of cycles.
- Set a control bit that stops user handlers from being preempted.
- Signal a return, which pops the saved level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `take` is 0, `cur_lvl` is 0, the stack is empty and every user priority field holds 4.
- R2: A user source competes only if its pending flag is set, its enable bit is set and its priority field is non-zero. Priority 0 never requests service.
- R3: A pending flag is set by its set strobe and stays set until its clear strobe. Accepting the source does not clear it, so a handler that returns without clearing it is re-entered on the next cycle.
- R4: A competing source is accepted only if its level is strictly greater than `cur_lvl`. On the clock edge after a request becomes visible, `take` rises for that cycle, `vec` gives the winner and the old level is pushed. `vec` is trap j → j and user i → N_TRAP + i.
- R5: Among competing sources the highest level wins. Between user sources on equal levels, the lowest index wins.
- R6: Trap j sits at level 15 − j and is taken whenever it exceeds `cur_lvl`. Enable bits, the timed mask, the nesting-disable bit and a current level of 7 do not affect traps. Only clearing a trap's flag stops it from being re-entered.
- R7: While `cur_lvl` is 7, no user source is taken. Software writes the level with `lvl_wr`/`lvl_val`.
- R8: `mask_load` loads a counter from `mask_cycles`. While the counter is non-zero, user sources at levels 1 to 6 are held off and level 7 sources can still be taken. Once the counter reaches zero, held sources are taken.
- R9: While `nest_dis` is 1, accepting a user source sets `cur_lvl` to 7, so no other user source preempts that handler.
- R10: `ret_stb` pops the most recently saved level into `cur_lvl`.
- R11: In a cycle with `ret_stb` or `lvl_wr` asserted, no source is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | N_SRC | Per-source event strobes that set pending flags |
| src_clr | input | N_SRC | Per-source software clear of pending flags |
| src_en | input | N_SRC | Per-source enable bits |
| prio_wr | input | 1 | Write strobe for one priority field |
| prio_idx | input | clog2(N_SRC) | Source whose priority is written |
| prio_val | input | 3 | New priority value |
| trap_set | input | N_TRAP | Trap event strobes |
| trap_clr | input | N_TRAP | Trap flag clears |
| nest_dis | input | 1 | Nesting-disable control bit |
| mask_load | input | 1 | Starts the timed mask |
| mask_cycles | input | CNT_W | Length of the timed mask in cycles |
| lvl_wr | input | 1 | Software write of the current level |
| lvl_val | input | 4 | Value for `lvl_wr` (0 to 7) |
| ret_stb | input | 1 | Return-from-handler strobe |
| take | output | 1 | One-cycle acceptance pulse |
| vec | output | clog2(N_TRAP+N_SRC) | Vector index of the accepted source |
| cur_lvl | output | 4 | Current CPU priority level |

## Verification
The assertions assume the following about the inputs:
- `ret_stb` arrives only while at least one saved level sits on the stack.
- Nesting never goes deeper than the stack.
- Software writes only user levels 0 to 7 through `lvl_wr`.

The stimulus stays within these limits. Each scenario starts from a fresh reset, every return strobe is paired with an earlier acceptance, and nesting stays at two or three levels. Direct level writes use only 0 or 7.

// File: rtl/irq_prio_pkg.sv
// Package: shared level type and level constants for the interrupt controller.
// Assumes levels are 4 bits wide: 0..7 for user sources, 8..15 for traps.
package irq_prio_pkg;
    localparam int LVL_W = 4;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_USER_TOP = 4'd7;
    localparam logic [2:0] PRIO_RESET = 3'd4;
endpackage

// File: rtl/irq_src_bank.sv
// User source bank: pending flags, priority fields and the timed-mask counter.
// For each source it produces the level with which that source competes (0 = not competing).
// Assumes set and clear strobes are one cycle wide; set wins over clear in the same cycle.
module irq_src_bank
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int CNT_W = 8,
    localparam int SIDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_set,
    input  logic [N_SRC-1:0]        src_clr,
    input  logic [N_SRC-1:0]        src_en,
    input  logic                    prio_wr,
    input  logic [SIDX_W-1:0]       prio_idx,
    input  logic [2:0]              prio_val,
    input  logic                    mask_load,
    input  logic [CNT_W-1:0]        mask_cycles,
    output logic [N_SRC-1:0][LVL_W-1:0] req_lvl,
    output logic                    mask_on
);
    logic [N_SRC-1:0]       pend;
    logic [N_SRC-1:0][2:0]  prio;
    logic [CNT_W-1:0]       mask_cnt;

    // Pending flags: held until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~src_clr) | src_set;
    end

    // Priority fields: all start at the reset value, written one at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) prio[i] <= PRIO_RESET;
        end else if (prio_wr) begin
            prio[prio_idx] <= prio_val;
        end
    end

    // Timed mask counter: loads on command, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             mask_cnt <= '0;
        else if (mask_load)     mask_cnt <= mask_cycles;
        else if (mask_cnt != 0) mask_cnt <= mask_cnt - 1'b1;
    end

    assign mask_on = (mask_cnt != 0);

    // Per-source competing level, gated by pending, enable and the timed mask.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic live;
        assign live = pend[i] && src_en[i] && (!mask_on || prio[i] == 3'd7);
        assign req_lvl[i] = live ? {1'b0, prio[i]} : '0;
    end

    // R3: a set flag with no clear stays set on the next edge.
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(pend & ~src_clr)) == $past(pend & ~src_clr)));
endmodule

// File: rtl/irq_arbiter.sv
// Arbiter: picks the entry with the highest level; equal levels go to the lowest index.
// Reports a hit when that level is strictly above the current CPU level.
// Assumes a level of 0 marks an entry that is not competing.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int N = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][LVL_W-1:0] lvl,
    input  lvl_t                    cur_lvl,
    output logic                    hit,
    output logic [IW-1:0]           sel,
    output lvl_t                    sel_lvl
);
    // Linear scan: replace the best entry only on a strictly higher level.
    always_comb begin
        sel_lvl = '0;
        sel     = '0;
        for (int i = 0; i < N; i++) begin
            if (lvl[i] > sel_lvl) begin
                sel_lvl = lvl[i];
                sel     = IW'(i);
            end
        end
        hit = (sel_lvl > cur_lvl);
    end
endmodule

// File: rtl/irq_lvl_stack.sv
// Level stack: holds the current CPU level and the levels saved by nested acceptances.
// Priority inside one cycle: software write, then pop, then push.
// Assumes pop only when not empty and push only when not full.
module irq_lvl_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    input  logic wr,
    input  lvl_t wr_lvl,
    output lvl_t cur_lvl,
    output logic empty
);
    lvl_t            mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic            full;
    logic [AW-1:0]   top_idx;

    assign empty   = (sp == 0);
    assign full    = (sp == SP_W'(DEPTH));
    assign top_idx = AW'(sp - 1'b1);

    // Current level and stack pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= '0;
            sp      <= '0;
        end else if (wr) begin
            cur_lvl <= wr_lvl;
        end else if (pop) begin
            cur_lvl <= empty ? '0 : mem[top_idx];
            if (!empty) sp <= sp - 1'b1;
        end else if (push) begin
            cur_lvl <= push_lvl;
            sp      <= sp + 1'b1;
        end
    end

    // Saved-level storage: written with the outgoing level on push.
    always_ff @(posedge clk) begin
        if (!wr && !pop && push && !full) mem[AW'(sp)] <= cur_lvl;
    end

    // R4: an acceptance never arrives with the stack full.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: a pop restores the level saved on top of the stack.
    p_pop_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr && !empty) |=> (cur_lvl == $past(mem[top_idx])));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: prioritized interrupt controller with user sources and unmaskable traps.
// Trap j sits at level 15-j; user source i competes at its priority field.
// Vector index is trap j -> j and user i -> N_TRAP+i.
// Assumes N_TRAP <= 8, ret_stb only while a level is saved, and lvl_val within 0..7.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int N_SRC     = 8,
    parameter int N_TRAP    = 4,
    parameter int STK_DEPTH = 16,
    parameter int CNT_W     = 8,
    localparam int SIDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int N_ALL  = N_TRAP + N_SRC,
    localparam int VEC_W  = $clog2(N_ALL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_set,
    input  logic [N_SRC-1:0]  src_clr,
    input  logic [N_SRC-1:0]  src_en,
    input  logic              prio_wr,
    input  logic [SIDX_W-1:0] prio_idx,
    input  logic [2:0]        prio_val,
    input  logic [N_TRAP-1:0] trap_set,
    input  logic [N_TRAP-1:0] trap_clr,
    input  logic              nest_dis,
    input  logic              mask_load,
    input  logic [CNT_W-1:0]  mask_cycles,
    input  logic              lvl_wr,
    input  logic [3:0]        lvl_val,
    input  logic              ret_stb,
    output logic              take,
    output logic [VEC_W-1:0]  vec,
    output logic [3:0]        cur_lvl
);
    logic [N_SRC-1:0][LVL_W-1:0] usr_lvl;
    logic [N_ALL-1:0][LVL_W-1:0] all_lvl;
    logic [N_TRAP-1:0]           trap_pend;
    logic                        mask_on;
    logic                        hit;
    logic [VEC_W-1:0]            sel;
    lvl_t                        sel_lvl;
    lvl_t                        new_lvl;
    logic                        accept;
    logic                        stk_empty;

    irq_src_bank #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .src_set(src_set), .src_clr(src_clr), .src_en(src_en),
        .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
        .mask_load(mask_load), .mask_cycles(mask_cycles),
        .req_lvl(usr_lvl), .mask_on(mask_on)
    );

    // Trap flags: held until cleared, never masked.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_pend <= '0;
        else        trap_pend <= (trap_pend & ~trap_clr) | trap_set;
    end

    // Arbiter entries: traps first on fixed high levels, then user sources.
    for (genvar j = 0; j < N_TRAP; j++) begin : g_trap
        assign all_lvl[j] = trap_pend[j] ? LVL_W'(15 - j) : '0;
    end
    for (genvar i = 0; i < N_SRC; i++) begin : g_usr
        assign all_lvl[N_TRAP + i] = usr_lvl[i];
    end

    irq_arbiter #(.N(N_ALL)) u_arb (
        .lvl(all_lvl), .cur_lvl(cur_lvl),
        .hit(hit), .sel(sel), .sel_lvl(sel_lvl)
    );

    assign accept  = hit && !ret_stb && !lvl_wr;
    assign new_lvl = (sel >= VEC_W'(N_TRAP) && nest_dis) ? LVL_USER_TOP : sel_lvl;

    irq_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_lvl(new_lvl),
        .pop(ret_stb), .wr(lvl_wr), .wr_lvl(lvl_val),
        .cur_lvl(cur_lvl), .empty(stk_empty)
    );

    // Acceptance pulse and vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take <= 1'b0;
            vec  <= '0;
        end else begin
            take <= accept;
            if (accept) vec <= sel;
        end
    end

    // R4: every acceptance raises the CPU level.
    p_take_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cur_lvl > $past(cur_lvl)));
    // R7: no user source is taken while the level is 7 or above.
    p_lvl7_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec >= VEC_W'(N_TRAP)) |-> ($past(cur_lvl) < 4'd7));
    // R8: under the timed mask only a level-7 user source gets through.
    p_mask_lvl7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec >= VEC_W'(N_TRAP) && $past(mask_on)) |-> (cur_lvl == 4'd7));
    // R9: with nesting disabled a user acceptance lands on level 7.
    p_nest_lvl7_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec >= VEC_W'(N_TRAP) && $past(nest_dis)) |-> (cur_lvl == 4'd7));
    // R10: a return is only issued while a level is saved.
    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_stb |-> !stk_empty);
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int N_SRC = 8;
    localparam int N_TRAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_SRC-1:0]  src_set = '0, src_clr = '0, src_en = '0;
    logic              prio_wr = 1'b0;
    logic [2:0]        prio_idx = '0;
    logic [2:0]        prio_val = '0;
    logic [N_TRAP-1:0] trap_set = '0, trap_clr = '0;
    logic              nest_dis = 1'b0, mask_load = 1'b0;
    logic [7:0]        mask_cycles = '0;
    logic              lvl_wr = 1'b0;
    logic [3:0]        lvl_val = '0;
    logic              ret_stb = 1'b0;
    logic              take;
    logic [3:0]        vec;
    logic [3:0]        cur_lvl;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n),
        .src_set(src_set), .src_clr(src_clr), .src_en(src_en),
        .prio_wr(prio_wr), .prio_idx(prio_idx), .prio_val(prio_val),
        .trap_set(trap_set), .trap_clr(trap_clr),
        .nest_dis(nest_dis), .mask_load(mask_load), .mask_cycles(mask_cycles),
        .lvl_wr(lvl_wr), .lvl_val(lvl_val), .ret_stb(ret_stb),
        .take(take), .vec(vec), .cur_lvl(cur_lvl)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_take(input string req, input int v, input int l);
        check(req, "take", int'(take), 1);
        check(req, "vec", int'(vec), v);
        check(req, "cur_lvl", int'(cur_lvl), l);
    endtask

    task automatic expect_idle(input string req, input int cycles, input int l);
        for (int k = 0; k < cycles; k++) begin
            step();
            check(req, "take", int'(take), 0);
        end
        check(req, "cur_lvl", int'(cur_lvl), l);
    endtask

    task automatic do_reset();
        src_set = '0; src_clr = '0; src_en = '0; prio_wr = 1'b0;
        trap_set = '0; trap_clr = '0; nest_dis = 1'b0; mask_load = 1'b0;
        lvl_wr = 1'b0; ret_stb = 1'b0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr_prio(input int idx, input int val);
        prio_idx = 3'(idx); prio_val = 3'(val); prio_wr = 1'b1;
        step();
        prio_wr = 1'b0;
    endtask

    task automatic set_src(input logic [N_SRC-1:0] m);
        src_set = m;
        step();
        src_set = '0;
    endtask

    task automatic set_trap(input logic [N_TRAP-1:0] m);
        trap_set = m;
        step();
        trap_set = '0;
    endtask

    task automatic do_ret(input logic [N_SRC-1:0] sc, input logic [N_TRAP-1:0] tc);
        src_clr = sc; trap_clr = tc; ret_stb = 1'b1;
        step();
        src_clr = '0; trap_clr = '0; ret_stb = 1'b0;
    endtask

    // R1, R4: reset state and default priority 4 on first acceptance.
    task automatic t_reset();
        do_reset();
        check("R1", "take", int'(take), 0);
        check("R1", "cur_lvl", int'(cur_lvl), 0);
        src_en = 8'h08;
        set_src(8'h08);
        step();
        expect_take("R1", 4 + 3, 4);
        step();
        check("R4", "take pulse", int'(take), 0);
    endtask

    // R2: disabled or priority-0 sources never compete.
    task automatic t_gate();
        do_reset();
        set_src(8'h02);
        expect_idle("R2", 3, 0);
        wr_prio(1, 0);
        src_en = 8'h02;
        expect_idle("R2", 3, 0);
        wr_prio(1, 2);
        step();
        expect_take("R2", 4 + 1, 2);
    endtask

    // R5, R10, R11: highest level first, ties to the lowest index, returns pop.
    task automatic t_arb();
        do_reset();
        wr_prio(5, 6); wr_prio(2, 3); wr_prio(6, 6);
        src_en = 8'h64;
        set_src(8'h64);
        step();
        expect_take("R5", 4 + 5, 6);
        do_ret(8'h20, '0);
        check("R10", "cur_lvl", int'(cur_lvl), 0);
        check("R11", "take", int'(take), 0);
        step();
        expect_take("R5", 4 + 6, 6);
        do_ret(8'h40, '0);
        step();
        expect_take("R5", 4 + 2, 3);
    endtask

    // R3: a handler that returns without clearing is re-entered.
    task automatic t_reentry();
        do_reset();
        src_en = 8'h01;
        set_src(8'h01);
        step();
        expect_take("R3", 4, 4);
        do_ret('0, '0);
        check("R3", "cur_lvl", int'(cur_lvl), 0);
        step();
        expect_take("R3", 4, 4);
    endtask

    // R4, R10: a higher source preempts; return restores the saved level.
    task automatic t_preempt();
        do_reset();
        wr_prio(0, 2); wr_prio(1, 5);
        src_en = 8'h03;
        set_src(8'h01);
        step();
        expect_take("R4", 4, 2);
        set_src(8'h02);
        step();
        expect_take("R4", 5, 5);
        do_ret(8'h02, '0);
        check("R10", "cur_lvl", int'(cur_lvl), 2);
        step();
        check("R4", "equal level not taken", int'(take), 0);
    endtask

    // R9, R6: nesting disable blocks user preemption but not traps.
    task automatic t_nestdis();
        do_reset();
        nest_dis = 1'b1;
        wr_prio(0, 2); wr_prio(1, 5);
        src_en = 8'h03;
        set_src(8'h01);
        step();
        expect_take("R9", 4, 7);
        set_src(8'h02);
        expect_idle("R9", 3, 7);
        set_trap(4'h1);
        step();
        expect_take("R6", 0, 15);
    endtask

    // R7, R6: level 7 blocks users; traps pass; clearing a trap stops re-entry.
    task automatic t_lvl7();
        do_reset();
        lvl_val = 4'd7; lvl_wr = 1'b1;
        step();
        lvl_wr = 1'b0;
        check("R7", "cur_lvl", int'(cur_lvl), 7);
        wr_prio(3, 7);
        src_en = 8'h08;
        set_src(8'h08);
        expect_idle("R7", 3, 7);
        set_trap(4'h4);
        step();
        expect_take("R6", 2, 13);
        do_ret('0, 4'h4);
        check("R6", "cur_lvl", int'(cur_lvl), 7);
        step();
        check("R6", "cleared trap", int'(take), 0);
        set_trap(4'h2);
        step();
        expect_take("R6", 1, 14);
        do_ret('0, '0);
        step();
        expect_take("R6", 1, 14);
    endtask

    // R8: timed mask holds levels 1..6, lets level 7 through, then releases.
    task automatic t_mask();
        do_reset();
        wr_prio(0, 5); wr_prio(1, 7);
        src_en = 8'h03;
        mask_cycles = 8'd12; mask_load = 1'b1;
        step();
        mask_load = 1'b0;
        set_src(8'h01);
        expect_idle("R8", 3, 0);
        set_src(8'h02);
        step();
        expect_take("R8", 5, 7);
        do_ret(8'h02, '0);
        check("R8", "cur_lvl", int'(cur_lvl), 0);
        expect_idle("R8", 2, 0);
        for (int k = 0; k < 6; k++) step();
        check("R8", "released cur_lvl", int'(cur_lvl), 5);
    endtask

    // R11: a level write cycle accepts nothing.
    task automatic t_wr_suppress();
        do_reset();
        src_en = 8'h01;
        lvl_val = 4'd0; lvl_wr = 1'b1;
        set_src(8'h01);
        expect_idle("R11", 3, 0);
        lvl_wr = 1'b0;
        step();
        expect_take("R11", 4, 4);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_gate();
        t_arb();
        t_reentry();
        t_preempt();
        t_nestdis();
        t_lvl7();
        t_mask();
        t_wr_suppress();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule